// File: doc/BRIEF.md
# Clock Synchronizer Operating-Mode Controller

This block decides which operating state a network clock synchronizer is in: locked to a reference (Normal), coasting on stored settings (Holdover), running from the local oscillator alone (Free-run), or coasting automatically because the active reference has failed (Auto Holdover). A two-bit mode request comes either from dedicated pins or from register bits. A hardware-control select input chooses the source, and the same select also picks the source of the filter-select, reference-select and realign controls. The request takes effect only on the rising edge of the frame pulse.

Each reference supplies a fail indication (loss of signal, or frequency drift far outside the capture range). These indications are asynchronous and pass through a two-flop synchronizer. While the block is in Normal, a failure of the selected reference moves it into Auto Holdover with no processor action. When that reference recovers, the block returns to Normal. The block refuses a Normal request while every reference has failed. It remembers the refused request and enters Normal at the first frame pulse after any reference becomes good. The combined holdover status appears on a dedicated output and in a status byte, and both stay active under either control source.

Top module: `sync_mode_ctrl`

## Requirements
- R1: While reset is high, the block goes to Free-run: `state_o`=2'b10, `holdover_o`=0, `lock_o`=0, `status_o`=8'h00.
- R2: The mode request codes are 00 for Normal, 01 for Holdover and 10 for Free-run. The request is acted on only in the cycle where `frame_pulse` is high and was low in the previous cycle. A request that is held steady, or applied while `frame_pulse` stays high, has no effect. The `state_o` encoding is 00 Normal, 01 Holdover, 10 Free-run, 11 Auto Holdover.
- R3: In Normal, a failure on the selected reference leads to Auto Holdover (11). The fail input passes through two synchronizer flops, so the state changes on the third rising clock edge after the input changes, and not on the first.
- R4: In Auto Holdover, the block returns to Normal once the selected reference is no longer failed. No request or frame pulse is needed for this.
- R5: The reserved code 11 leaves the state unchanged when no refused Normal request is pending.
- R6: A Normal request at a frame pulse while every reference is failed is refused: the state does not become Normal.
- R7: A refused Normal request stays pending. At the first frame pulse at which at least one reference is good, the block enters Normal, even if the request code is then 11. A Holdover or Free-run request cancels the pending request.
- R8: `holdover_o` is 1 in Holdover and in Auto Holdover. `status_o` bit 4 carries the same value, `status_o` bit 0 carries `lock_o` (1 only in Normal), and all other status bits are 0.
- R9: With `hw_ctrl`=1, the mode, filter, reference-select and realign controls come from the pin inputs. With `hw_ctrl`=0 they come from the register inputs, and the pins have no effect. `holdover_o` and `lock_o` work under both settings.
- R10: Only the reference named by the effective reference select can trigger Auto Holdover (0 selects reference 0, 1 selects reference 1). A failure on any other reference leaves Normal unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| hw_ctrl | input | 1 | 1: controls from pins, 0: controls from register bits |
| pin_mode | input | 2 | Mode request pins |
| pin_filter | input | 1 | Filter characteristic select pin |
| pin_ref_sel | input | REF_W | Reference select pins |
| pin_realign | input | 1 | Realign request pin |
| reg_mode | input | 2 | Mode request register bits |
| reg_filter | input | 1 | Filter select register bit |
| reg_ref_sel | input | REF_W | Reference select register bits |
| reg_realign | input | 1 | Realign register bit |
| ref_fail | input | NUM_REFS | Asynchronous per-reference fail indications |
| frame_pulse | input | 1 | Frame pulse; its rising edge samples the request |
| state_o | output | 2 | Current operating state |
| holdover_o | output | 1 | Combined holdover status |
| lock_o | output | 1 | High in Normal |
| status_o | output | 8 | Status byte: bit 4 holdover, bit 0 lock |
| filter_sel_o | output | 1 | Effective filter select |
| ref_sel_o | output | REF_W | Effective reference select |
| realign_o | output | 1 | Effective realign control |

## Verification
On every cycle, the assertions check that requested states hold steady between frame-pulse edges, that the automatic moves between Normal and Auto Holdover follow the synchronized fail of the selected reference, that a Normal request is never honoured while all references are lost, that the reserved code is inert, and that the status byte matches the holdover and lock outputs. Some behaviour can only be shown by the bench's scenarios, because it depends on what the block sees at its ports over several cycles. This covers the three-edge latency through the synchronizer, the pending Normal request that completes later under the reserved code, the switch between pin and register sources, and the effect of the reference select on which failure counts.

// File: rtl/sync_mode_pkg.sv
package sync_mode_pkg;

    typedef enum logic [1:0] {
        REQ_NORMAL = 2'b00,
        REQ_HOLD   = 2'b01,
        REQ_FREE   = 2'b10,
        REQ_RSVD   = 2'b11
    } mode_req_e;

    typedef enum logic [1:0] {
        ST_NORMAL = 2'b00,
        ST_HOLD   = 2'b01,
        ST_FREE   = 2'b10,
        ST_AUTO   = 2'b11
    } op_state_e;

    localparam int STAT_W        = 8;
    localparam int STAT_HOLD_BIT = 4;
    localparam int STAT_LOCK_BIT = 0;

    function automatic logic is_coasting(op_state_e s);
        return (s == ST_HOLD) || (s == ST_AUTO);
    endfunction

    function automatic logic [STAT_W-1:0] pack_status(logic hold, logic lock);
        logic [STAT_W-1:0] v;
        v = '0;
        v[STAT_HOLD_BIT] = hold;
        v[STAT_LOCK_BIT] = lock;
        return v;
    endfunction

endpackage

// File: rtl/sync_mode_src_mux.sv
module sync_mode_src_mux
    import sync_mode_pkg::*;
#(
    parameter int REF_W = 1
) (
    input  logic             hw_ctrl,
    input  logic [1:0]       pin_mode,
    input  logic             pin_filter,
    input  logic [REF_W-1:0] pin_ref_sel,
    input  logic             pin_realign,
    input  logic [1:0]       reg_mode,
    input  logic             reg_filter,
    input  logic [REF_W-1:0] reg_ref_sel,
    input  logic             reg_realign,
    output mode_req_e        req_o,
    output logic             filter_o,
    output logic [REF_W-1:0] ref_sel_o,
    output logic             realign_o
);

    always_comb begin
        if (hw_ctrl) begin
            req_o     = mode_req_e'(pin_mode);
            filter_o  = pin_filter;
            ref_sel_o = pin_ref_sel;
            realign_o = pin_realign;
        end else begin
            req_o     = mode_req_e'(reg_mode);
            filter_o  = reg_filter;
            ref_sel_o = reg_ref_sel;
            realign_o = reg_realign;
        end
    end

endmodule

// File: rtl/sync_mode_fail_sync.sv
module sync_mode_fail_sync #(
    parameter int NUM_REFS = 2,
    parameter int STAGES   = 2
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [NUM_REFS-1:0] fail_raw,
    output logic [NUM_REFS-1:0] fail_s
);

    generate
        for (genvar g = 0; g < NUM_REFS; g++) begin : g_ref
            logic [STAGES-1:0] chain_q;
            always_ff @(posedge clk) begin
                if (rst) chain_q <= '1;
                else     chain_q <= {chain_q[STAGES-2:0], fail_raw[g]};
            end
            assign fail_s[g] = chain_q[STAGES-1];
        end
    endgenerate

endmodule

// File: rtl/sync_mode_fsm.sv
module sync_mode_fsm
    import sync_mode_pkg::*;
#(
    parameter int NUM_REFS = 2,
    parameter int REF_W    = 1
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                frame_pulse,
    input  mode_req_e           req,
    input  logic [NUM_REFS-1:0] fail_s,
    input  logic [REF_W-1:0]    ref_sel,
    output op_state_e           state_q,
    output logic                pend_q
);

    logic      fp_d_q;
    logic      fp_rise;
    logic      act_fail;
    logic      all_lost;
    op_state_e st_n;
    logic      pend_n;

    always_ff @(posedge clk) begin
        if (rst) fp_d_q <= 1'b0;
        else     fp_d_q <= frame_pulse;
    end

    assign fp_rise  = frame_pulse & ~fp_d_q;
    assign act_fail = fail_s[ref_sel];
    assign all_lost = &fail_s;

    always_comb begin
        st_n   = state_q;
        pend_n = pend_q;
        if (fp_rise && (req != REQ_RSVD || pend_q)) begin
            case (req)
                REQ_NORMAL, REQ_RSVD: begin
                    if (all_lost) begin
                        pend_n = 1'b1;
                        if (state_q == ST_NORMAL) st_n = ST_AUTO;
                    end else begin
                        pend_n = 1'b0;
                        st_n   = act_fail ? ST_AUTO : ST_NORMAL;
                    end
                end
                REQ_HOLD: begin
                    pend_n = 1'b0;
                    st_n   = ST_HOLD;
                end
                default: begin
                    pend_n = 1'b0;
                    st_n   = ST_FREE;
                end
            endcase
        end else if (state_q == ST_NORMAL && act_fail) begin
            st_n = ST_AUTO;
        end else if (state_q == ST_AUTO && !act_fail) begin
            st_n = ST_NORMAL;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_FREE;
            pend_q  <= 1'b0;
        end else begin
            state_q <= st_n;
            pend_q  <= pend_n;
        end
    end

    // R2: requested states move only on a frame-pulse rising edge
    p_req_only_on_edge_r2: assert property (@(posedge clk) disable iff (rst)
        (!fp_rise && (state_q == ST_HOLD || state_q == ST_FREE)) |=> $stable(state_q));

    // R3: Normal with a failed selected reference enters Auto Holdover
    p_auto_entry_r3: assert property (@(posedge clk) disable iff (rst)
        (!fp_rise && state_q == ST_NORMAL && act_fail) |=> state_q == ST_AUTO);

    // R4: Auto Holdover leaves to Normal on recovery
    p_auto_exit_r4: assert property (@(posedge clk) disable iff (rst)
        (!fp_rise && state_q == ST_AUTO && !act_fail) |=> state_q == ST_NORMAL);

    // R5: reserved code with nothing pending is inert
    p_reserved_inert_r5: assert property (@(posedge clk) disable iff (rst)
        (fp_rise && req == REQ_RSVD && !pend_q && (state_q == ST_HOLD || state_q == ST_FREE))
        |=> $stable(state_q));

    // R6: Normal never honoured with every reference lost
    p_refuse_normal_r6: assert property (@(posedge clk) disable iff (rst)
        (fp_rise && req == REQ_NORMAL && all_lost) |=> (state_q != ST_NORMAL && pend_q));

endmodule

// File: rtl/sync_mode_ctrl.sv
module sync_mode_ctrl
    import sync_mode_pkg::*;
#(
    parameter int NUM_REFS    = 2,
    parameter int SYNC_STAGES = 2,
    localparam int REF_W      = (NUM_REFS > 1) ? $clog2(NUM_REFS) : 1
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                hw_ctrl,
    input  logic [1:0]          pin_mode,
    input  logic                pin_filter,
    input  logic [REF_W-1:0]    pin_ref_sel,
    input  logic                pin_realign,
    input  logic [1:0]          reg_mode,
    input  logic                reg_filter,
    input  logic [REF_W-1:0]    reg_ref_sel,
    input  logic                reg_realign,
    input  logic [NUM_REFS-1:0] ref_fail,
    input  logic                frame_pulse,
    output logic [1:0]          state_o,
    output logic                holdover_o,
    output logic                lock_o,
    output logic [7:0]          status_o,
    output logic                filter_sel_o,
    output logic [REF_W-1:0]    ref_sel_o,
    output logic                realign_o
);

    mode_req_e             req;
    logic [NUM_REFS-1:0]   fail_s;
    op_state_e             state_q;
    logic                  pend_q;

    sync_mode_src_mux #(.REF_W(REF_W)) u_mux (
        .hw_ctrl     (hw_ctrl),
        .pin_mode    (pin_mode),
        .pin_filter  (pin_filter),
        .pin_ref_sel (pin_ref_sel),
        .pin_realign (pin_realign),
        .reg_mode    (reg_mode),
        .reg_filter  (reg_filter),
        .reg_ref_sel (reg_ref_sel),
        .reg_realign (reg_realign),
        .req_o       (req),
        .filter_o    (filter_sel_o),
        .ref_sel_o   (ref_sel_o),
        .realign_o   (realign_o)
    );

    sync_mode_fail_sync #(.NUM_REFS(NUM_REFS), .STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst      (rst),
        .fail_raw (ref_fail),
        .fail_s   (fail_s)
    );

    sync_mode_fsm #(.NUM_REFS(NUM_REFS), .REF_W(REF_W)) u_fsm (
        .clk         (clk),
        .rst         (rst),
        .frame_pulse (frame_pulse),
        .req         (req),
        .fail_s      (fail_s),
        .ref_sel     (ref_sel_o),
        .state_q     (state_q),
        .pend_q      (pend_q)
    );

    assign state_o    = state_q;
    assign holdover_o = is_coasting(state_q);
    assign lock_o     = (state_q == ST_NORMAL);
    assign status_o   = pack_status(holdover_o, lock_o);

    // R8: status byte agrees with the dedicated outputs
    p_status_match_r8: assert property (@(posedge clk) disable iff (rst)
        (status_o[STAT_HOLD_BIT] == holdover_o) && (status_o[STAT_LOCK_BIT] == lock_o)
        && !(holdover_o && lock_o));

endmodule

// File: tb/sync_mode_ctrl_bench.sv
module sync_mode_ctrl_bench;

    logic       clk = 1'b0;
    logic       rst;
    logic       hw_ctrl;
    logic [1:0] pin_mode, reg_mode;
    logic       pin_filter, reg_filter, pin_realign, reg_realign;
    logic [0:0] pin_ref_sel, reg_ref_sel;
    logic [1:0] ref_fail;
    logic       frame_pulse;
    logic [1:0] state_o;
    logic       holdover_o, lock_o, filter_sel_o, realign_o;
    logic [7:0] status_o;
    logic [0:0] ref_sel_o;

    int n_chk = 0;
    int n_bad = 0;

    always #2 clk = ~clk;

    sync_mode_ctrl u_sync_mode_ctrl (
        .clk(clk), .rst(rst), .hw_ctrl(hw_ctrl),
        .pin_mode(pin_mode), .pin_filter(pin_filter), .pin_ref_sel(pin_ref_sel),
        .pin_realign(pin_realign), .reg_mode(reg_mode), .reg_filter(reg_filter),
        .reg_ref_sel(reg_ref_sel), .reg_realign(reg_realign), .ref_fail(ref_fail),
        .frame_pulse(frame_pulse), .state_o(state_o), .holdover_o(holdover_o),
        .lock_o(lock_o), .status_o(status_o), .filter_sel_o(filter_sel_o),
        .ref_sel_o(ref_sel_o), .realign_o(realign_o)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wait_n(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic fp_pulse();
        frame_pulse = 1'b1;
        @(negedge clk);
        frame_pulse = 1'b0;
        @(negedge clk);
    endtask

    task automatic t_reset();
        rst = 1'b1;
        wait_n(3);
        chk("R1 state", state_o, 2'b10);
        chk("R1 holdover", holdover_o, 0);
        chk("R1 lock", lock_o, 0);
        chk("R1 status", status_o, 8'h00);
        rst = 1'b0;
        wait_n(3);
    endtask

    task automatic t_requests();
        pin_mode = 2'b00;
        wait_n(3);
        chk("R2 no edge no change", state_o, 2'b10);
        fp_pulse();
        chk("R2 normal", state_o, 2'b00);
        chk("R8 lock status", status_o, 8'h01);
        frame_pulse = 1'b1;
        wait_n(1);
        pin_mode = 2'b01;
        wait_n(3);
        chk("R2 level high ignored", state_o, 2'b00);
        frame_pulse = 1'b0;
        wait_n(1);
        fp_pulse();
        chk("R2 holdover", state_o, 2'b01);
        chk("R8 holdover pin", holdover_o, 1);
        chk("R8 holdover status", status_o, 8'h10);
        pin_mode = 2'b10;
        fp_pulse();
        chk("R2 freerun", state_o, 2'b10);
    endtask

    task automatic t_auto();
        pin_mode = 2'b00;
        fp_pulse();
        chk("R3 start normal", state_o, 2'b00);
        ref_fail = 2'b01;
        wait_n(1);
        chk("R3 not before sync", state_o, 2'b00);
        wait_n(3);
        chk("R3 auto holdover", state_o, 2'b11);
        chk("R8 auto status", status_o, 8'h10);
        ref_fail = 2'b00;
        wait_n(4);
        chk("R4 recover normal", state_o, 2'b00);
    endtask

    task automatic t_refsel();
        ref_fail = 2'b10;
        wait_n(4);
        chk("R10 other ref ignored", state_o, 2'b00);
        ref_fail = 2'b00;
        wait_n(4);
        pin_ref_sel = 1'b1;
        ref_fail = 2'b10;
        wait_n(4);
        chk("R10 selected ref fails", state_o, 2'b11);
        ref_fail = 2'b00;
        pin_ref_sel = 1'b0;
        wait_n(4);
        chk("R10 back normal", state_o, 2'b00);
    endtask

    task automatic t_reserved();
        pin_mode = 2'b01;
        fp_pulse();
        pin_mode = 2'b11;
        fp_pulse();
        chk("R5 reserved in holdover", state_o, 2'b01);
        pin_mode = 2'b10;
        fp_pulse();
        pin_mode = 2'b11;
        fp_pulse();
        chk("R5 reserved in freerun", state_o, 2'b10);
    endtask

    task automatic t_refuse();
        ref_fail = 2'b11;
        wait_n(4);
        pin_mode = 2'b00;
        fp_pulse();
        chk("R6 normal refused", state_o, 2'b10);
        pin_mode = 2'b11;
        fp_pulse();
        chk("R7 still lost", state_o, 2'b10);
        ref_fail = 2'b00;
        wait_n(4);
        chk("R7 waits for frame pulse", state_o, 2'b10);
        fp_pulse();
        chk("R7 pending completes", state_o, 2'b00);
        pin_mode = 2'b10;
        fp_pulse();
        pin_mode = 2'b11;
        fp_pulse();
        chk("R7 pending cleared", state_o, 2'b10);
    endtask

    task automatic t_sw();
        hw_ctrl = 1'b0;
        reg_mode = 2'b01;
        pin_mode = 2'b10;
        pin_filter = 1'b1;  reg_filter = 1'b0;
        pin_realign = 1'b0; reg_realign = 1'b1;
        pin_ref_sel = 1'b0; reg_ref_sel = 1'b1;
        fp_pulse();
        chk("R9 reg mode used", state_o, 2'b01);
        chk("R9 holdover in sw", holdover_o, 1);
        chk("R9 reg filter", filter_sel_o, 0);
        chk("R9 reg realign", realign_o, 1);
        chk("R9 reg ref sel", ref_sel_o, 1);
        hw_ctrl = 1'b1;
        wait_n(1);
        chk("R9 pin filter", filter_sel_o, 1);
        chk("R9 pin realign", realign_o, 0);
        chk("R9 pin ref sel", ref_sel_o, 0);
        fp_pulse();
        chk("R9 pin mode used", state_o, 2'b10);
    endtask

    initial begin
        #400000;
        n_bad++;
        $display("FAIL watchdog expired");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        rst = 1'b1; hw_ctrl = 1'b1;
        pin_mode = 2'b10; reg_mode = 2'b10;
        pin_filter = 1'b0; reg_filter = 1'b0;
        pin_realign = 1'b0; reg_realign = 1'b0;
        pin_ref_sel = 1'b0; reg_ref_sel = 1'b0;
        ref_fail = 2'b00; frame_pulse = 1'b0;
        @(negedge clk);
        t_reset();
        t_requests();
        t_auto();
        t_refsel();
        t_reserved();
        t_refuse();
        t_sw();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule